// File: doc/BRIEF.md
# Ring-Buffer Timebase Corrector

This block takes a sample stream whose words arrive at irregular moments and hands them back out at the steady pace of a reference-rate demand strobe. Both sides run on the system clock. The input side only ever presents a valid strobe with data. The output side asks for one word per demand pulse. Between them sits a single-port RAM used as a ring. A write pointer and a read pointer each wrap from the last location back to location zero.

Only one access can reach the RAM in a cycle, and the steady side always takes it. When a demand is present the cycle is a read and any write waits. Words that arrive during such a read queue in a four-entry front silo. That silo then requests the RAM, and its head word is written in the next cycle that carries no demand. Output starts only once the ring has filled to a nominal delay, so early inputs wait longer and late inputs wait less. If the ring empties, a demand returns a zero word and flags underrun. A word that reaches a full ring, or a full silo that cannot drain, is discarded and flagged.

Top module: `tbc_ring`

## Requirements
- R1: After synchronous reset, `out_valid`, `underrun`, `ring_drop` and `silo_drop` are low, the ring holds no words, and output is not yet enabled.
- R2: Words leave in the order they were accepted. Ordering holds across the wrap of the ring pointers when more words than DEPTH pass through.
- R3: Demands are ignored until ring occupancy has once reached NOM_DELAY. An ignored demand gives `out_valid` low and consumes no stored word. Once enabled, output stays enabled.
- R4: Once output is enabled, a demand sampled at clock edge t always wins the RAM, even when the silo holds words. `out_valid` is high with the word after edge t+1, and `out_valid` is never high without a demand one cycle earlier.
- R5: Up to four words arriving during an unbroken run of demand cycles are held in the silo. They are written to the ring, in order and without loss, in later cycles that carry no demand.
- R6: A word arriving while the silo holds four words and cannot drain that cycle is discarded. `silo_drop` is high for one cycle after that edge.
- R7: Ring occupancy never exceeds DEPTH. A silo word whose write finds the ring full is discarded, `ring_drop` pulses for one cycle, and the stored words are untouched.
- R8: A demand served while the ring is empty gives `out_valid` high with `out_data` equal to zero and `underrun` high, and it moves no pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Irregular input strobe |
| in_data | input | DATA_W | Input sample |
| rd_req | input | 1 | Reference-rate demand strobe |
| out_valid | output | 1 | Output sample valid, one cycle after a served demand |
| out_data | output | DATA_W | Output sample, zero on underrun |
| underrun | output | 1 | Demand served from an empty ring |
| ring_drop | output | 1 | Silo word discarded because the ring was full |
| silo_drop | output | 1 | Input word discarded because the silo was full |

## Verification
A wrong pointer or occupancy value in the ring shows up on the next served demand. It appears either as a word out of arrival order or as an underrun zero where a stored word was expected. A miscounted ring appears as a `ring_drop` pulse too early or too late during the fill to DEPTH. A silo count that is off by one appears as a `silo_drop` on the fourth queued word rather than the fifth, or as a lost word once the silo drains. A faulty enable appears as `out_valid` rising during the priming phase, one cycle after the offending demand.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // RAM access chosen for the current cycle
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ram_op_e;
endpackage

// File: rtl/tbc_silo.sv
module tbc_silo #(
  parameter int W = 16,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head,
  output logic         drop
);
  localparam int PW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);

  logic [W-1:0]  slot [D];
  logic [PW-1:0] rdp, wrp;
  logic [CW-1:0] cnt;
  logic          accept;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(D));
  assign head   = slot[rdp];
  assign accept = push_valid && (!full || pop);
  assign drop   = push_valid && full && !pop;

  always_ff @(posedge clk) begin
    if (accept) slot[wrp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdp <= '0;
      wrp <= '0;
      cnt <= '0;
    end else begin
      if (accept) wrp <= (wrp == PW'(D - 1)) ? '0 : wrp + 1'b1;
      if (pop)    rdp <= (rdp == PW'(D - 1)) ? '0 : rdp + 1'b1;
      cnt <= cnt + CW'(accept) - CW'(pop);
    end
  end
endmodule

// File: rtl/tbc_ram.sv
module tbc_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/tbc_arbiter.sv
module tbc_arbiter
  import tbc_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NOM_DELAY = DEPTH / 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int OW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          silo_empty,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic          silo_pop,
  output logic          rd_grant,
  output logic          underrun_hit,
  output logic          ring_full_hit,
  output logic [OW-1:0] occ,
  output logic          primed
);
  ram_op_e       op;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          ring_full, ring_empty, is_read, is_write;

  // steady side first, silo fills the remaining cycles
  always_comb begin
    op = OP_IDLE;
    if (rd_req && primed)  op = OP_READ;
    else if (!silo_empty)  op = OP_WRITE;
  end

  assign is_read       = (op == OP_READ);
  assign is_write      = (op == OP_WRITE);
  assign ring_full     = (occ == OW'(DEPTH));
  assign ring_empty    = (occ == '0);
  assign ram_we        = is_write && !ring_full;
  assign ram_re        = is_read && !ring_empty;
  assign ram_addr      = is_read ? rd_ptr : wr_ptr;
  assign silo_pop      = is_write;
  assign rd_grant      = is_read;
  assign underrun_hit  = is_read && ring_empty;
  assign ring_full_hit = is_write && ring_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      primed <= 1'b0;
    end else begin
      if (ram_we) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (ram_re) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      occ    <= occ + OW'(ram_we) - OW'(ram_re);
      primed <= primed || (occ >= OW'(NOM_DELAY));
    end
  end
endmodule

// File: rtl/tbc_ring.sv
module tbc_ring #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  parameter int NOM_DELAY = DEPTH / 2,
  parameter int SILO_D    = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int OW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              underrun,
  output logic              ring_drop,
  output logic              silo_drop
);
  logic              silo_empty, silo_full, silo_pop, silo_drop_hit;
  logic [DATA_W-1:0] silo_head, ram_q;
  logic              ram_we, ram_re, rd_grant, underrun_hit, ring_full_hit;
  logic [AW-1:0]     ram_addr;
  logic [OW-1:0]     occ;
  logic              primed;

  tbc_silo #(.W(DATA_W), .D(SILO_D)) u_silo (
    .clk(clk), .rst(rst),
    .push_valid(in_valid), .push_data(in_data), .pop(silo_pop),
    .empty(silo_empty), .full(silo_full), .head(silo_head), .drop(silo_drop_hit)
  );

  tbc_arbiter #(.DEPTH(DEPTH), .NOM_DELAY(NOM_DELAY)) u_arb (
    .clk(clk), .rst(rst), .rd_req(rd_req), .silo_empty(silo_empty),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .silo_pop(silo_pop), .rd_grant(rd_grant),
    .underrun_hit(underrun_hit), .ring_full_hit(ring_full_hit),
    .occ(occ), .primed(primed)
  );

  tbc_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(silo_head), .rdata(ram_q)
  );

  logic empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      empty_q   <= 1'b0;
      ring_drop <= 1'b0;
      silo_drop <= 1'b0;
    end else begin
      out_valid <= rd_grant;
      empty_q   <= underrun_hit;
      ring_drop <= ring_full_hit;
      silo_drop <= silo_drop_hit;
    end
  end

  assign underrun = empty_q;
  assign out_data = empty_q ? '0 : ram_q;
endmodule

// File: rtl/tbc_ring_chk.sv
module tbc_ring_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int OW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              rd_req,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              underrun,
  input logic              ring_drop,
  input logic              silo_drop,
  input logic [OW-1:0]     occ,
  input logic              primed,
  input logic              silo_full
);
  assert_quiet_until_primed_R3: assert property (@(posedge clk) disable iff (rst)
    rd_req && !primed |=> !out_valid);
  assert_primed_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    primed |=> primed);
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req && primed |=> out_valid);
  assert_valid_has_demand_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_req));
  assert_underrun_zero_R8: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (out_valid && out_data == '0));
  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(DEPTH));
  assert_ring_drop_full_R7: assert property (@(posedge clk) disable iff (rst)
    ring_drop |-> $past(occ) == OW'(DEPTH));
  assert_silo_drop_full_R6: assert property (@(posedge clk) disable iff (rst)
    silo_drop |-> $past(silo_full && in_valid));
  assert_occ_step_R2: assert property (@(posedge clk) disable iff (rst)
    (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ + 1'b1 == $past(occ)));
endmodule

bind tbc_ring tbc_ring_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rd_req(rd_req),
  .out_valid(out_valid), .out_data(out_data), .underrun(underrun),
  .ring_drop(ring_drop), .silo_drop(silo_drop),
  .occ(occ), .primed(primed), .silo_full(silo_full)
);

// File: tb/tbc_ring_bench.sv
module tbc_ring_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, in_valid, rd_req;
  logic [W-1:0] in_data;
  logic         out_valid, underrun, ring_drop, silo_drop;
  logic [W-1:0] out_data;

  tbc_ring #(.DATA_W(W), .DEPTH(16), .NOM_DELAY(8), .SILO_D(4)) u_tbc_ring (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .rd_req(rd_req),
    .out_valid(out_valid), .out_data(out_data), .underrun(underrun),
    .ring_drop(ring_drop), .silo_drop(silo_drop)
  );

  logic [W-1:0] mq [$];
  int vecs = 0, bad = 0, ring_drops = 0, silo_drops = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at next negedge
  task automatic step(bit iv, logic [W-1:0] d, bit rq, bit keep, bit expr, string tag);
    logic [W-1:0] e;
    in_valid = iv; in_data = d; rd_req = rq;
    @(posedge clk); @(negedge clk);
    in_valid = 0; rd_req = 0;
    if (ring_drop) ring_drops++;
    if (silo_drop) silo_drops++;
    if (expr) begin
      chk(out_valid == 1'b1, {tag, " out_valid"}, out_valid, 1);
      if (mq.size() == 0) begin
        chk(out_data == '0, {tag, " R8 zero data"}, out_data, 0);
        chk(underrun == 1'b1, {tag, " R8 underrun"}, underrun, 1);
      end else begin
        e = mq.pop_front();
        chk(out_data == e, {tag, " data"}, out_data, e);
        chk(underrun == 1'b0, {tag, " no underrun"}, underrun, 0);
      end
    end else begin
      chk(out_valid == 1'b0, {tag, " idle out_valid"}, out_valid, 0);
    end
    if (iv && keep) mq.push_back(d);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, tag);
  endtask

  task automatic t_reset;
    rst = 1; in_valid = 0; rd_req = 0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(underrun == 0, "R1 underrun", underrun, 0);
    chk(ring_drop == 0, "R1 ring_drop", ring_drop, 0);
    chk(silo_drop == 0, "R1 silo_drop", silo_drop, 0);
    step(0, '0, 1, 0, 0, "R1 demand after reset not served");
  endtask

  task automatic t_prime;
    for (int i = 0; i < 7; i++) step(1, W'(16'hA000 + i), 1, 1, 0, "R3 priming");
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0, "R3 below nominal");
    step(1, 16'hA007, 0, 1, 0, "R3 reach nominal");
    idle(3, "R3 settle");
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 1, "R2 first reads");
  endtask

  task automatic t_priority;
    for (int i = 0; i < 3; i++) step(1, W'(16'hB000 + i), 1, 1, 1, "R4 read over write");
    idle(4, "R4 drain");
  endtask

  task automatic t_silo;
    silo_drops = 0;
    for (int i = 0; i < 4; i++) step(1, W'(16'hC000 + i), 1, 1, 1, "R5 silo hold");
    step(0, '0, 1, 0, 1, "R5 silo hold");
    idle(4, "R5 drain");
    chk(silo_drops == 0, "R5 no silo drop", silo_drops, 0);
    for (int i = 0; i < 4; i++) step(1, W'(16'hE000 + i), 0, 1, 0, "R5 refill");
    idle(4, "R5 refill drain");
    for (int i = 0; i < 4; i++) step(1, W'(16'hD000 + i), 1, 1, 1, "R6 fill silo");
    step(1, 16'hD004, 1, 0, 1, "R6 overflow word");
    idle(4, "R6 drain");
    chk(silo_drops == 1, "R6 silo drop count", silo_drops, 1);
  endtask

  task automatic t_drain;
    for (int i = 0; i < 7; i++) step(0, '0, 1, 0, 1, "R2 wrap order");
  endtask

  task automatic t_underrun;
    step(0, '0, 1, 0, 1, "R8 empty read");
    step(1, 16'hF000, 0, 1, 0, "R8 refill");
    idle(2, "R8 settle");
    step(0, '0, 1, 0, 1, "R8 pointers unmoved");
  endtask

  task automatic t_ring_full;
    ring_drops = 0;
    for (int i = 0; i < 16; i++) step(1, W'(16'h1000 + i), 0, 1, 0, "R7 fill");
    step(1, 16'h1010, 0, 0, 0, "R7 excess word");
    idle(3, "R7 settle");
    chk(ring_drops == 1, "R7 ring drop count", ring_drops, 1);
    for (int i = 0; i < 17; i++) step(0, '0, 1, 0, 1, "R7 contents kept");
  endtask

  initial begin
    t_reset();
    t_prime();
    t_order();
    t_priority();
    t_silo();
    t_drain();
    t_underrun();
    t_ring_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule